// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Status

This block sits between a register bus and a serial audio engine and buffers samples in both directions. It holds one transmit queue, filled by bus writes and drained by the engine, and one receive queue, filled by the engine and drained by bus reads. Each queue stores eight 32-bit words and reports its fill level, full, empty and a programmable threshold flag.

Four sticky error flags record overflow and underflow events and are cleared by writing 1. A clear command empties a queue by resetting its pointers and level; the command bit drops back to 0 by itself. Two DMA request lines ask for service: one while the transmit queue has room, one while the receive queue holds data. Three interrupt lines come from per-source enables: one for the receive side, one for the transmit side (which also carries the left and right zero-cross events from the engine), and one global line.

Top module: `audio_fifo_pair`

## Requirements
- R1: Each queue holds up to 8 words of 32 bits in first-in first-out order. Its level output counts from 0 to 8, its empty output is 1 at level 0, and its full output is 1 at level 8. All are 0 except empty after reset.
- R2: txThrFlag is 1 while txLevel is less than or equal to txThresh (3 bits), and 0 while txLevel is greater.
- R3: rxThrFlag is 1 while rxLevel is greater than or equal to rxThresh (3 bits), and 0 while rxLevel is smaller.
- R4: A bus write to a full transmit queue sets stickyFlags[3] (transmit overflow). The word is dropped, the level stays 8, and the flag stays set until it is cleared.
- R5: An engine push into a full receive queue sets stickyFlags[1] (receive overflow). The sample is lost, so later reads return only the eight earlier words.
- R6: A bus read of an empty receive queue sets stickyFlags[0] (receive underflow). An engine pop of an empty transmit queue sets stickyFlags[2] (transmit underflow).
- R7: A 1 in bit n of stickyClr clears stickyFlags[n] at the next edge and leaves the other flags as they are. Bit map: 0 receive underflow, 1 receive overflow, 2 transmit underflow, 3 transmit overflow.
- R8: A pulse on clrTxWr or clrRxWr raises clrPending[0] (transmit) or clrPending[1] (receive) at the next edge. At the edge after that, the queue's level goes to 0 and the pending bit returns to 0. Pushes and pops made while the bit is 1 are ignored and raise no flag. The stored words are not altered, so the head-data port then shows the word held in slot 0.
- R9: txDmaReq is 1 when txDmaEn is 1 and the transmit queue is not full. rxDmaReq is 1 when rxDmaEn is 1 and the receive queue is not empty.
- R10: rxIrq is the OR of the receive underflow, overflow and threshold flags, each gated by its intEn bit. txIrq is the OR of the transmit underflow, overflow and threshold flags and the zcRight and zcLeft inputs, each gated by its intEn bit. anyIrq is rxIrq OR txIrq. intEn bit map: 0 rx underflow, 1 rx overflow, 2 rx threshold, 3 tx underflow, 4 tx overflow, 5 tx threshold, 6 right zero-cross, 7 left zero-cross.
- R11: A push and a pop in the same cycle on a queue that is neither full nor empty both succeed, and the level is unchanged.
- R12: When a set event and a write of 1 to the same sticky flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busTxWrite | input | 1 | Bus write strobe into the transmit queue |
| busTxData | input | 32 | Word written to the transmit queue |
| busRxRead | input | 1 | Bus read strobe popping the receive queue |
| busRxData | output | 32 | Head word of the receive queue |
| engTxPop | input | 1 | Engine request for the next transmit word |
| engTxData | output | 32 | Head word of the transmit queue |
| engRxPush | input | 1 | Engine strobe pushing a received sample |
| engRxData | input | 32 | Sample pushed by the engine |
| clrTxWr | input | 1 | Write of 1 to the transmit clear bit |
| clrRxWr | input | 1 | Write of 1 to the receive clear bit |
| stickyClr | input | 4 | Write-1-to-clear strobes for the sticky flags |
| txThresh | input | 3 | Transmit threshold |
| rxThresh | input | 3 | Receive threshold |
| txDmaEn | input | 1 | Transmit DMA enable |
| rxDmaEn | input | 1 | Receive DMA enable |
| intEn | input | 8 | Interrupt source enables |
| zcLeft | input | 1 | Left-channel zero-cross flag from the engine |
| zcRight | input | 1 | Right-channel zero-cross flag from the engine |
| txLevel | output | 4 | Transmit fill level |
| rxLevel | output | 4 | Receive fill level |
| txFull | output | 1 | Transmit queue full |
| txEmpty | output | 1 | Transmit queue empty |
| rxFull | output | 1 | Receive queue full |
| rxEmpty | output | 1 | Receive queue empty |
| txThrFlag | output | 1 | Transmit threshold flag |
| rxThrFlag | output | 1 | Receive threshold flag |
| stickyFlags | output | 4 | Sticky overflow and underflow flags |
| clrPending | output | 2 | Self-clearing clear bits (0 tx, 1 rx) |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |
| txIrq | output | 1 | Transmit interrupt |
| rxIrq | output | 1 | Receive interrupt |
| anyIrq | output | 1 | Global interrupt |

## Verification
Two pairs of functions can fall in the same cycle. A flag's write-1-to-clear can coincide with its set event, and a push can coincide with a pop on one queue. The bench provokes the first by writing a full transmit queue while pulsing stickyClr[3], and expects the overflow flag still set. It provokes the second by writing and popping the transmit queue together for several cycles at level 2; the level must hold at 2, and the scoreboard checks each popped word against the queue of words written.

// File: rtl/afp_pkg.sv
package afp_pkg;
  // Strobes from control to a queue datapath; already qualified by status.
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoStb_t;

  localparam int FLAG_RX_UDF = 0;
  localparam int FLAG_RX_OVF = 1;
  localparam int FLAG_TX_UDF = 2;
  localparam int FLAG_TX_OVF = 3;
  localparam int FLAG_N      = 4;

  localparam int IE_RX_UDF = 0;
  localparam int IE_RX_OVF = 1;
  localparam int IE_RX_THR = 2;
  localparam int IE_TX_UDF = 3;
  localparam int IE_TX_OVF = 4;
  localparam int IE_TX_THR = 5;
  localparam int IE_ZC_R   = 6;
  localparam int IE_ZC_L   = 7;
  localparam int IE_N      = 8;
endpackage

// File: rtl/afp_fifo_store.sv
module afp_fifo_store
  import afp_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fifoStb_t         stb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrNext, rdNext;
  logic [LVL_W-1:0] count;

  // Pointer advance: free wrap for power-of-two depths, compare otherwise.
  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wrNext = wrPtr + PTR_W'(1);
      assign rdNext = rdPtr + PTR_W'(1);
    end else begin : g_wrap
      assign wrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      assign rdNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
    end
  endgenerate

  // Storage has no reset; a clear only moves pointers.
  always_ff @(posedge clk) begin
    if (stb.push && !stb.clear) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (stb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) wrPtr <= wrNext;
      if (stb.pop)  rdPtr <= rdNext;
      case ({stb.push, stb.pop})
        2'b10:   count <= count + LVL_W'(1);
        2'b01:   count <= count - LVL_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign rdData = mem[rdPtr];
  assign level  = count;
  assign full   = (count == LVL_W'(DEPTH));
  assign empty  = (count == '0);

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LVL_W'(DEPTH));

  a_r4_push_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    stb.push |-> !full);

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clear |=> (count == '0));

  a_r11_pushpop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.push && stb.pop && !stb.clear) |=> $stable(count));
endmodule

// File: rtl/afp_ctrl.sv
module afp_ctrl
  import afp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int THR_W = 3,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busTxWrite,
  input  logic              busRxRead,
  input  logic              engTxPop,
  input  logic              engRxPush,
  input  logic              clrTxWr,
  input  logic              clrRxWr,
  input  logic [FLAG_N-1:0] stickyClr,
  input  logic [THR_W-1:0]  txThresh,
  input  logic [THR_W-1:0]  rxThresh,
  input  logic              txDmaEn,
  input  logic              rxDmaEn,
  input  logic [IE_N-1:0]   intEn,
  input  logic              zcLeft,
  input  logic              zcRight,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              txFull,
  input  logic              txEmpty,
  input  logic              rxFull,
  input  logic              rxEmpty,
  output fifoStb_t          txStb,
  output fifoStb_t          rxStb,
  output logic              txThrFlag,
  output logic              rxThrFlag,
  output logic [FLAG_N-1:0] stickyFlags,
  output logic [1:0]        clrPending,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              anyIrq
);
  logic clrTxPend, clrRxPend;
  logic [FLAG_N-1:0] flagSet, flagQ;

  // Qualified strobes; a pending clear masks all traffic on its queue.
  always_comb begin
    txStb.clear = clrTxPend;
    txStb.push  = busTxWrite && !txFull  && !clrTxPend;
    txStb.pop   = engTxPop   && !txEmpty && !clrTxPend;
    rxStb.clear = clrRxPend;
    rxStb.push  = engRxPush  && !rxFull  && !clrRxPend;
    rxStb.pop   = busRxRead  && !rxEmpty && !clrRxPend;
  end

  always_comb begin
    flagSet              = '0;
    flagSet[FLAG_TX_OVF] = busTxWrite && txFull  && !clrTxPend;
    flagSet[FLAG_TX_UDF] = engTxPop   && txEmpty && !clrTxPend;
    flagSet[FLAG_RX_OVF] = engRxPush  && rxFull  && !clrRxPend;
    flagSet[FLAG_RX_UDF] = busRxRead  && rxEmpty && !clrRxPend;
  end

  // Set has priority over write-one-to-clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flagQ <= '0;
    else        flagQ <= flagSet | (flagQ & ~stickyClr);
  end

  // Clear bits: set by a write, held one cycle while the clear executes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clrTxPend <= 1'b0;
      clrRxPend <= 1'b0;
    end else begin
      clrTxPend <= clrTxWr;
      clrRxPend <= clrRxWr;
    end
  end

  assign txThrFlag   = (txLevel <= LVL_W'(txThresh));
  assign rxThrFlag   = (rxLevel >= LVL_W'(rxThresh));
  assign stickyFlags = flagQ;
  assign clrPending  = {clrRxPend, clrTxPend};
  assign txDmaReq    = txDmaEn && !txFull;
  assign rxDmaReq    = rxDmaEn && !rxEmpty;

  assign rxIrq = (intEn[IE_RX_UDF] && flagQ[FLAG_RX_UDF])
              || (intEn[IE_RX_OVF] && flagQ[FLAG_RX_OVF])
              || (intEn[IE_RX_THR] && rxThrFlag);
  assign txIrq = (intEn[IE_TX_UDF] && flagQ[FLAG_TX_UDF])
              || (intEn[IE_TX_OVF] && flagQ[FLAG_TX_OVF])
              || (intEn[IE_TX_THR] && txThrFlag)
              || (intEn[IE_ZC_R]   && zcRight)
              || (intEn[IE_ZC_L]   && zcLeft);
  assign anyIrq = txIrq || rxIrq;

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flagQ[FLAG_TX_OVF] && !stickyClr[FLAG_TX_OVF]) |=> flagQ[FLAG_TX_OVF]);

  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (busTxWrite && txFull && !clrTxPend) |=> flagQ[FLAG_TX_OVF]);

  a_r8_clear_self_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clrTxPend && !clrTxWr) |=> !clrTxPend);

  a_r9_rx_dma_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    rxDmaReq |-> (rxLevel != '0));
endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair
  import afp_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  parameter int THR_W = 3,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busTxWrite,
  input  logic [WIDTH-1:0]  busTxData,
  input  logic              busRxRead,
  output logic [WIDTH-1:0]  busRxData,
  input  logic              engTxPop,
  output logic [WIDTH-1:0]  engTxData,
  input  logic              engRxPush,
  input  logic [WIDTH-1:0]  engRxData,
  input  logic              clrTxWr,
  input  logic              clrRxWr,
  input  logic [FLAG_N-1:0] stickyClr,
  input  logic [THR_W-1:0]  txThresh,
  input  logic [THR_W-1:0]  rxThresh,
  input  logic              txDmaEn,
  input  logic              rxDmaEn,
  input  logic [IE_N-1:0]   intEn,
  input  logic              zcLeft,
  input  logic              zcRight,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              txFull,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic              txThrFlag,
  output logic              rxThrFlag,
  output logic [FLAG_N-1:0] stickyFlags,
  output logic [1:0]        clrPending,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              anyIrq
);
  fifoStb_t txStb, rxStb;

  afp_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .busTxWrite(busTxWrite), .busRxRead(busRxRead),
    .engTxPop(engTxPop), .engRxPush(engRxPush),
    .clrTxWr(clrTxWr), .clrRxWr(clrRxWr), .stickyClr(stickyClr),
    .txThresh(txThresh), .rxThresh(rxThresh),
    .txDmaEn(txDmaEn), .rxDmaEn(rxDmaEn), .intEn(intEn),
    .zcLeft(zcLeft), .zcRight(zcRight),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .txStb(txStb), .rxStb(rxStb),
    .txThrFlag(txThrFlag), .rxThrFlag(rxThrFlag),
    .stickyFlags(stickyFlags), .clrPending(clrPending),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq),
    .txIrq(txIrq), .rxIrq(rxIrq), .anyIrq(anyIrq)
  );

  afp_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_txStore (
    .clk(clk), .rst_n(rst_n), .stb(txStb),
    .wrData(busTxData), .rdData(engTxData),
    .level(txLevel), .full(txFull), .empty(txEmpty)
  );

  afp_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_rxStore (
    .clk(clk), .rst_n(rst_n), .stb(rxStb),
    .wrData(engRxData), .rdData(busRxData),
    .level(rxLevel), .full(rxFull), .empty(rxEmpty)
  );
endmodule

// File: tb/sim_audio_fifo_pair.sv
module sim_audio_fifo_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busTxWrite = 0, busRxRead = 0, engTxPop = 0, engRxPush = 0;
  logic [31:0] busTxData = '0, engRxData = '0;
  logic [31:0] busRxData, engTxData;
  logic        clrTxWr = 0, clrRxWr = 0;
  logic [3:0]  stickyClr = '0;
  logic [2:0]  txThresh = 3'd3, rxThresh = 3'd5;
  logic        txDmaEn = 0, rxDmaEn = 0;
  logic [7:0]  intEn = '0;
  logic        zcLeft = 0, zcRight = 0;
  logic [3:0]  txLevel, rxLevel;
  logic        txFull, txEmpty, rxFull, rxEmpty, txThrFlag, rxThrFlag;
  logic [3:0]  stickyFlags;
  logic [1:0]  clrPending;
  logic        txDmaReq, rxDmaReq, txIrq, rxIrq, anyIrq;

  int checks = 0;
  int errors = 0;
  logic [31:0] txQ[$];
  logic [31:0] rxQ[$];

  always #2.5 clk = ~clk;

  audio_fifo_pair u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic txWrite(input logic [31:0] d);
    busTxWrite = 1; busTxData = d;
    if (txQ.size() < 8) txQ.push_back(d);
    tick();
    busTxWrite = 0;
  endtask

  task automatic rxPush(input logic [31:0] d);
    engRxPush = 1; engRxData = d;
    if (rxQ.size() < 8) rxQ.push_back(d);
    tick();
    engRxPush = 0;
  endtask

  // Monitor: compares popped head words against the scoreboard queues (R1).
  always @(negedge clk) begin
    if (rst_n && engTxPop && clrPending[0] == 1'b0 && txQ.size() > 0) begin
      logic [31:0] e;
      e = txQ.pop_front();
      chk(engTxData == e, "R1 tx order", engTxData, e);
    end
    if (rst_n && busRxRead && clrPending[1] == 1'b0 && rxQ.size() > 0) begin
      logic [31:0] e;
      e = rxQ.pop_front();
      chk(busRxData == e, "R1 rx order R5", busRxData, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 reset state
    chk(txLevel == 0 && rxLevel == 0, "R1 reset levels", {txLevel, rxLevel}, 0);
    chk(txEmpty && rxEmpty && !txFull && !rxFull, "R1 reset status",
        {txEmpty, rxEmpty, txFull, rxFull}, 4'b1100);
    chk(stickyFlags == 0 && clrPending == 0, "R1 reset flags", stickyFlags, 0);
    chk(!anyIrq && !txDmaReq && !rxDmaReq, "R10 reset irq", anyIrq, 0);
    chk(txThrFlag == 1 && rxThrFlag == 0, "R2 R3 reset thresholds",
        {txThrFlag, rxThrFlag}, 2'b10);

    // R2 transmit threshold, R1 fill to full
    for (int i = 0; i < 8; i++) begin
      txWrite(32'hA0 + i);
      if (i == 2) chk(txThrFlag == 1, "R2 tx level 3 at thr 3", txThrFlag, 1);
      if (i == 3) chk(txThrFlag == 0, "R2 tx level 4 above thr 3", txThrFlag, 0);
    end
    chk(txLevel == 8 && txFull, "R1 tx full at 8", txLevel, 8);

    // R4 overflow
    txWrite(32'hDEAD);
    chk(stickyFlags[3] == 1, "R4 tx overflow set", stickyFlags, 4'b1000);
    chk(txLevel == 8, "R4 tx level stays 8", txLevel, 8);
    tick();
    chk(stickyFlags[3] == 1, "R4 tx overflow sticky", stickyFlags, 4'b1000);

    // Drain through the scoreboard (R1), then underflow (R6)
    engTxPop = 1;
    repeat (8) tick();
    engTxPop = 0;
    chk(txEmpty && txLevel == 0, "R1 tx drained", txLevel, 0);
    engTxPop = 1; tick(); engTxPop = 0;
    chk(stickyFlags == 4'b1100, "R6 tx underflow set", stickyFlags, 4'b1100);

    // R7 selective write-one-to-clear
    stickyClr = 4'b0100; tick(); stickyClr = 0;
    chk(stickyFlags == 4'b1000, "R7 clear only bit 2", stickyFlags, 4'b1000);
    stickyClr = 4'b1000; tick(); stickyClr = 0;
    chk(stickyFlags == 4'b0000, "R7 clear bit 3", stickyFlags, 0);

    // R3 receive threshold, R5 receive overflow
    for (int i = 0; i < 8; i++) begin
      rxPush(32'hB0 + i);
      if (i == 3) chk(rxThrFlag == 0, "R3 rx level 4 below thr 5", rxThrFlag, 0);
      if (i == 4) chk(rxThrFlag == 1, "R3 rx level 5 at thr 5", rxThrFlag, 1);
    end
    chk(rxFull && rxLevel == 8, "R1 rx full", rxLevel, 8);
    rxPush(32'hBAD);
    chk(stickyFlags == 4'b0010, "R5 rx overflow set", stickyFlags, 4'b0010);
    chk(rxLevel == 8, "R5 rx level stays 8", rxLevel, 8);
    busRxRead = 1;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (i == 3) chk(rxThrFlag == 0, "R3 rx drops below thr", rxThrFlag, 0);
    end
    busRxRead = 0;
    chk(rxEmpty, "R5 rx empty after eight reads", rxLevel, 0);
    busRxRead = 1; tick(); busRxRead = 0;
    chk(stickyFlags == 4'b0011, "R6 rx underflow set", stickyFlags, 4'b0011);
    stickyClr = 4'b0011; tick(); stickyClr = 0;
    chk(stickyFlags == 0, "R7 clear rx flags", stickyFlags, 0);

    // R12 set wins over clear
    for (int i = 0; i < 8; i++) txWrite(32'hC0 + i);
    txWrite(32'hEE);
    busTxWrite = 1; busTxData = 32'hEF; stickyClr = 4'b1000;
    tick();
    busTxWrite = 0; stickyClr = 0;
    chk(stickyFlags[3] == 1, "R12 set wins over clear", stickyFlags, 4'b1000);
    stickyClr = 4'b1000; tick(); stickyClr = 0;
    chk(stickyFlags == 0, "R7 clear after set", stickyFlags, 0);

    // R8 transmit clear
    engTxPop = 1; repeat (2) tick(); engTxPop = 0;
    chk(txLevel == 6, "R8 tx level before clear", txLevel, 6);
    clrTxWr = 1; tick(); clrTxWr = 0;
    chk(clrPending == 2'b01, "R8 tx clear pending", clrPending, 2'b01);
    chk(txLevel == 6, "R8 level held while pending", txLevel, 6);
    busTxWrite = 1; busTxData = 32'h55; tick(); busTxWrite = 0;
    txQ.delete();
    chk(clrPending == 0, "R8 clear bit self-drops", clrPending, 0);
    chk(txLevel == 0 && txEmpty, "R8 tx emptied", txLevel, 0);
    chk(engTxData == 32'hC0, "R8 stored data kept", engTxData, 32'hC0);
    chk(stickyFlags == 0, "R8 ignored write no flag", stickyFlags, 0);

    // R8 receive clear
    rxPush(32'hD0); rxPush(32'hD1);
    clrRxWr = 1; tick(); clrRxWr = 0;
    chk(clrPending == 2'b10, "R8 rx clear pending", clrPending, 2'b10);
    tick();
    rxQ.delete();
    chk(rxLevel == 0 && clrPending == 0, "R8 rx emptied", rxLevel, 0);
    chk(busRxData == 32'hD0, "R8 rx stored data kept", busRxData, 32'hD0);

    // R11 simultaneous push and pop
    txWrite(32'hE0); txWrite(32'hE1);
    engTxPop = 1;
    for (int i = 0; i < 3; i++) begin
      busTxWrite = 1; busTxData = 32'hE2 + i;
      txQ.push_back(32'hE2 + i);
      tick();
      chk(txLevel == 2, "R11 level held on push and pop", txLevel, 2);
    end
    busTxWrite = 0; engTxPop = 0;

    // R9 DMA requests
    chk(txDmaReq == 0, "R9 tx dma off when disabled", txDmaReq, 0);
    txDmaEn = 1; #1;
    chk(txDmaReq == 1, "R9 tx dma when room", txDmaReq, 1);
    for (int i = 0; i < 6; i++) txWrite(32'hF8 + i);
    chk(txFull && txDmaReq == 0, "R9 tx dma off when full", txDmaReq, 0);
    rxDmaEn = 1; #1;
    chk(rxDmaReq == 0, "R9 rx dma off when empty", rxDmaReq, 0);
    rxPush(32'hF0);
    chk(rxDmaReq == 1, "R9 rx dma when data", rxDmaReq, 1);

    // R10 interrupt grouping (rx level 1, tx level 8, flags clear)
    rxThresh = 3'd1; #1;
    chk(!anyIrq, "R10 no irq with enables off", anyIrq, 0);
    intEn = 8'h04; #1;
    chk(rxIrq && anyIrq && !txIrq, "R10 rx threshold irq",
        {rxIrq, txIrq, anyIrq}, 3'b101);
    intEn = 8'h20; #1;
    chk(!txIrq, "R10 tx threshold not met", txIrq, 0);
    intEn = 8'h40; zcRight = 1; #1;
    chk(txIrq && anyIrq && !rxIrq, "R10 right zero-cross irq",
        {rxIrq, txIrq, anyIrq}, 3'b011);
    zcRight = 0; zcLeft = 1; #1;
    chk(!txIrq, "R10 left zero-cross masked", txIrq, 0);
    intEn = 8'h80; #1;
    chk(txIrq && anyIrq, "R10 left zero-cross irq", txIrq, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule